// File: doc/BRIEF.md
# Register Producer Tag Table

This block sits beside the issue stage of an out-of-order core that uses reservation stations and a shared result broadcast bus. For every architectural register it keeps one of two states. The register is either ready, holding its committed value, or pending, holding the tag of the station that will produce its next value. When an instruction issues, two source registers are looked up in the same cycle. Each lookup returns either a ready value or the tag of the producing station. The issuing station's tag is then written over the destination register's tag.

The table also watches the result broadcast bus. A register takes a broadcast value only when the broadcast tag equals the tag the register is currently waiting on. A result from an older writer is therefore discarded once a younger instruction has claimed the same register. This removes write-after-write and write-after-read hazards without stalling issue.

Source lookups are combinational and read the table state as it stood before the same cycle's destination claim. A lookup that hits a register whose producer is broadcasting in that cycle gets the broadcast value directly.

Top module: `rename_status_table`

## Requirements
- R1: A synchronous active-high reset marks every register ready and loads register i with slice [i*DATA_W +: DATA_W] of `init_vals`.
- R2: A lookup of a ready register returns ready=1 and the register's value. A lookup of a pending register returns ready=0 and the pending producer tag, with no bypass.
- R3: An issue with `iss_valid`=1 makes register `iss_dst` pending on `iss_tag` from the next cycle on. This holds even if that register was already pending on another tag.
- R4: A broadcast with `bc_valid`=1 whose tag equals a pending register's tag makes that register ready with `bc_data` from the next cycle on. With `bc_valid`=0 the register is not changed.
- R5: A broadcast whose tag differs from a pending register's current tag does not change that register. This includes the case where the tag belongs to an older writer that was replaced.
- R6: A lookup in the same cycle as an issue to the same register sees the state from before that issue.
- R7: A lookup of a register pending on the tag being broadcast in the same cycle returns ready=1 with `bc_data`.
- R8: When an issue claim and a matching broadcast target the same register in one cycle, the register ends pending on the new issue tag.
- R9: The two lookup ports operate independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_vals | input | NUM_REGS*DATA_W | Reset values, register i at [i*DATA_W +: DATA_W] |
| iss_valid | input | 1 | Destination claim this cycle |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Issuing station tag |
| src_a_idx | input | IDX_W | Lookup port A register index |
| src_a_ready | output | 1 | Port A value is valid |
| src_a_value | output | DATA_W | Port A value |
| src_a_tag | output | TAG_W | Port A producer tag when not ready, else 0 |
| src_b_idx | input | IDX_W | Lookup port B register index |
| src_b_ready | output | 1 | Port B value is valid |
| src_b_value | output | DATA_W | Port B value |
| src_b_tag | output | TAG_W | Port B producer tag when not ready, else 0 |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcasting station |
| bc_data | input | DATA_W | Broadcast result |

## Verification
The assertions check the per-register update rules on every cycle:
- a claim installs the new tag;
- a matching broadcast clears the register and loads its data;
- a non-matching broadcast leaves the register untouched;
- a claim wins over a simultaneous clear.

Only the bench scenarios can show the orderings seen from the ports. These include the write-after-write sequence where an older result arrives late and the same-cycle read-before-claim case. They also include the broadcast bypass into a lookup, the reset loading of supplied values, and the independence of the two lookup ports.

// File: rtl/rst_pkg.sv
package rst_pkg;

    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_TAG_W    = 3;

    typedef enum logic {
        REG_READY   = 1'b0,
        REG_PENDING = 1'b1
    } reg_state_e;

    function automatic logic tag_match(input reg_state_e st, input logic bc_v,
                                       input logic [31:0] a, input logic [31:0] b);
        return (st == REG_PENDING) && bc_v && (a == b);
    endfunction

endpackage

// File: rtl/rst_entry.sv
module rst_entry
    import rst_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int TAG_W  = DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] init_val,
    input  logic              claim,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output reg_state_e        state,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value
);

    logic hit;
    assign hit = tag_match(state, bc_valid, 32'(tag), 32'(bc_tag));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= REG_READY;
            tag   <= '0;
            value <= init_val;
        end else if (claim) begin
            state <= REG_PENDING;
            tag   <= claim_tag;
        end else if (hit) begin
            state <= REG_READY;
            value <= bc_data;
        end
    end

    // R3
    claim_sets_tag_chk: assert property (@(posedge clk) disable iff (rst)
        claim |=> (state == REG_PENDING) && (tag == $past(claim_tag)));

    // R4
    bcast_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !claim) |=> (state == REG_READY) && (value == $past(bc_data)));

    // R5
    stale_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == REG_PENDING) && bc_valid && (bc_tag != tag) && !claim)
        |=> (state == REG_PENDING) && $stable(tag) && $stable(value));

    // R8
    claim_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (claim && hit) |=> (state == REG_PENDING));

endmodule

// File: rtl/rst_lookup.sv
module rst_lookup
    import rst_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TAG_W    = DEF_TAG_W,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    input  reg_state_e        ent_state [NUM_REGS],
    input  logic [TAG_W-1:0]  ent_tag   [NUM_REGS],
    input  logic [DATA_W-1:0] ent_value [NUM_REGS],
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              ready,
    output logic [DATA_W-1:0] value,
    output logic [TAG_W-1:0]  tag
);

    reg_state_e        sel_state;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_value;

    always_comb begin
        sel_state = ent_state[idx];
        sel_tag   = ent_tag[idx];
        sel_value = ent_value[idx];
        if (sel_state == REG_READY) begin
            ready = 1'b1;
            value = sel_value;
            tag   = '0;
        end else if (tag_match(sel_state, bc_valid, 32'(sel_tag), 32'(bc_tag))) begin
            ready = 1'b1;
            value = bc_data;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = sel_tag;
        end
    end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
    import rst_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TAG_W    = DEF_TAG_W,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REGS*DATA_W-1:0] init_vals,
    input  logic                       iss_valid,
    input  logic [IDX_W-1:0]           iss_dst,
    input  logic [TAG_W-1:0]           iss_tag,
    input  logic [IDX_W-1:0]           src_a_idx,
    output logic                       src_a_ready,
    output logic [DATA_W-1:0]          src_a_value,
    output logic [TAG_W-1:0]           src_a_tag,
    input  logic [IDX_W-1:0]           src_b_idx,
    output logic                       src_b_ready,
    output logic [DATA_W-1:0]          src_b_value,
    output logic [TAG_W-1:0]           src_b_tag,
    input  logic                       bc_valid,
    input  logic [TAG_W-1:0]           bc_tag,
    input  logic [DATA_W-1:0]          bc_data
);

    reg_state_e        ent_state [NUM_REGS];
    logic [TAG_W-1:0]  ent_tag   [NUM_REGS];
    logic [DATA_W-1:0] ent_value [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic claim_here;
        assign claim_here = iss_valid && (iss_dst == IDX_W'(g));

        rst_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .init_val  (init_vals[g*DATA_W +: DATA_W]),
            .claim     (claim_here),
            .claim_tag (iss_tag),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_data   (bc_data),
            .state     (ent_state[g]),
            .tag       (ent_tag[g]),
            .value     (ent_value[g])
        );
    end

    rst_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_a (
        .idx       (src_a_idx),
        .ent_state (ent_state),
        .ent_tag   (ent_tag),
        .ent_value (ent_value),
        .bc_valid  (bc_valid),
        .bc_tag    (bc_tag),
        .bc_data   (bc_data),
        .ready     (src_a_ready),
        .value     (src_a_value),
        .tag       (src_a_tag)
    );

    rst_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_b (
        .idx       (src_b_idx),
        .ent_state (ent_state),
        .ent_tag   (ent_tag),
        .ent_value (ent_value),
        .bc_valid  (bc_valid),
        .bc_tag    (bc_tag),
        .bc_data   (bc_data),
        .ready     (src_b_ready),
        .value     (src_b_value),
        .tag       (src_b_tag)
    );

endmodule

// File: tb/rename_status_table_bench.sv
module rename_status_table_bench;

    localparam int NR = 8;
    localparam int DW = 32;
    localparam int TW = 3;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic [NR*DW-1:0] init_vals;
    logic           iss_valid;
    logic [IW-1:0]  iss_dst;
    logic [TW-1:0]  iss_tag;
    logic [IW-1:0]  src_a_idx, src_b_idx;
    logic           src_a_ready, src_b_ready;
    logic [DW-1:0]  src_a_value, src_b_value;
    logic [TW-1:0]  src_a_tag, src_b_tag;
    logic           bc_valid;
    logic [TW-1:0]  bc_tag;
    logic [DW-1:0]  bc_data;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    rename_status_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) u_rename_status_table (
        .clk(clk), .rst(rst), .init_vals(init_vals),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .src_a_idx(src_a_idx), .src_a_ready(src_a_ready),
        .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_ready(src_b_ready),
        .src_b_value(src_b_value), .src_b_tag(src_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
    );

    function automatic logic [DW-1:0] init_of(int i);
        return 32'h0000_0100 + 32'(i);
    endfunction

    task automatic quiet();
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        quiet();
    endtask

    // Looks up a register on one port; expects value when ready, tag otherwise.
    task automatic look(input bit on_b, input int idx, input bit exp_rdy,
                        input logic [DW-1:0] exp_val, input logic [TW-1:0] exp_tag,
                        input string req);
        logic r;
        logic [DW-1:0] v;
        logic [TW-1:0] t;
        if (on_b) src_b_idx = IW'(idx); else src_a_idx = IW'(idx);
        #1;
        r = on_b ? src_b_ready : src_a_ready;
        v = on_b ? src_b_value : src_a_value;
        t = on_b ? src_b_tag   : src_a_tag;
        vectors++;
        if (r !== exp_rdy || (exp_rdy && v !== exp_val) || (!exp_rdy && t !== exp_tag)) begin
            miscompares++;
            $display("FAIL %s reg%0d: got ready=%0b value=%h tag=%0d, want ready=%0b value=%h tag=%0d",
                     req, idx, r, v, t, exp_rdy, exp_val, exp_tag);
        end
    endtask

    task automatic issue(input int dst, input int tg);
        iss_valid = 1'b1;
        iss_dst   = IW'(dst);
        iss_tag   = TW'(tg);
    endtask

    task automatic bcast(input int tg, input logic [DW-1:0] d);
        bc_valid = 1'b1;
        bc_tag   = TW'(tg);
        bc_data  = d;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        for (int i = 0; i < NR; i++) look(i[0], i, 1'b1, init_of(i), '0, "R1");
    endtask

    task automatic t_issue_then_clear();
        issue(3, 2);
        tick();
        look(0, 3, 1'b0, '0, 3'd2, "R3/R2");
        look(1, 3, 1'b0, '0, 3'd2, "R9");
        bc_valid = 1'b0; bc_tag = 3'd2; bc_data = 32'hDEAD_0000;
        tick();
        look(0, 3, 1'b0, '0, 3'd2, "R4 no-valid");
        bcast(2, 32'hCAFE_0003);
        tick();
        look(0, 3, 1'b1, 32'hCAFE_0003, '0, "R4");
    endtask

    task automatic t_waw();
        issue(5, 1);
        tick();
        issue(5, 4);
        tick();
        bcast(1, 32'h1111_1111);
        tick();
        look(0, 5, 1'b0, '0, 3'd4, "R5");
        bcast(4, 32'h4444_4444);
        tick();
        look(1, 5, 1'b1, 32'h4444_4444, '0, "R4 young");
    endtask

    task automatic t_read_before_claim();
        issue(2, 5);
        look(0, 2, 1'b1, init_of(2), '0, "R6");
        tick();
        look(0, 2, 1'b0, '0, 3'd5, "R6 after");
    endtask

    task automatic t_bypass();
        issue(6, 3);
        tick();
        bcast(3, 32'hBEEF_0006);
        look(0, 6, 1'b1, 32'hBEEF_0006, '0, "R7");
        look(1, 0, 1'b1, init_of(0), '0, "R9");
        tick();
        look(0, 6, 1'b1, 32'hBEEF_0006, '0, "R4 bypass");
    endtask

    task automatic t_collision();
        issue(7, 1);
        tick();
        issue(7, 6);
        bcast(1, 32'h7777_0001);
        tick();
        look(0, 7, 1'b0, '0, 3'd6, "R8");
        bcast(6, 32'h7777_0006);
        tick();
        look(1, 7, 1'b1, 32'h7777_0006, '0, "R8 clear");
        look(0, 2, 1'b0, '0, 3'd5, "R5 other");
    endtask

    initial begin
        for (int i = 0; i < NR; i++) init_vals[i*DW +: DW] = init_of(i);
        rst = 1'b1;
        quiet();
        iss_dst = '0; iss_tag = '0; bc_tag = '0; bc_data = '0;
        src_a_idx = '0; src_b_idx = '0;
        @(negedge clk);
        t_reset();
        t_issue_then_clear();
        t_waw();
        t_read_before_claim();
        t_bypass();
        t_collision();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hung run, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule